// File: doc/BRIEF.md
# Three-Wire Timekeeper Link Master

This block is the host side of a slow three-wire serial link to a timekeeping slave. It turns one command into a complete frame, so software never toggles the link lines by hand. A command carries a direction (read or write), a 3-bit slave address and, for writes, a 32-bit word. The engine first confirms that the slave reports itself ready. It then drives the enable, clock and data-out lines with a fixed half-period and, on a read, collects 32 bits from the slave's data-out line.

Readiness is checked in bounded windows. An empty window is followed by a pause and another window. After a set number of empty windows in a row, the slave is pulsed into reset and a fresh round starts. Once every reset has been used and a final round also comes up empty, the command ends with an error. Each command ends with a one-cycle completion pulse that carries the error flag. A command presented while the engine is occupied is refused at once and is never queued.

The write frame sends the data field first and then the address. The read frame sends the address, and the slave's word follows the mode bit. In both frames the mode bit is the first pulse after enable drops: 1 means write and 0 means read.

Top module: `rtl_link_master`

## Requirements
- R1: After reset, busy, done, err, req_rej, rtc_sen, rtc_sclk, rtc_sdi and rtc_srst are all 0 and rdata is 0.
- R2: A request (req_valid high) is accepted only when busy is 0, and busy stays 1 until done. A request that arrives while busy is 1 causes req_rej to be 1 for one cycle in the next cycle. That request is dropped: no further frame and no further done follow it.
- R3: During the ready wait, rtc_sen, rtc_sclk and rtc_sdi are 0. rtc_sen goes to 1 only in the cycle after rtc_ready is sampled high. With rtc_ready already high, rtc_sen rises 1 cycle after the acceptance edge.
- R4: Every clock pulse is rtc_sclk low for HALF_CYC cycles and then high for HALF_CYC cycles, where HALF_CYC = CLK_MHZ*HALF_US. rtc_sdi and rtc_sen do not change while rtc_sclk is high.
- R5: A write frame, with rtc_sen at 1, sends the 32 data bits most significant first and then the 3 address bits most significant first. rtc_sen then drops, and one mode pulse follows with rtc_sdi = 1. The frame has 36 pulses in total.
- R6: A read frame, with rtc_sen at 1, sends the 3 address bits most significant first. rtc_sen then drops, one mode pulse follows with rtc_sdi = 0, and then 32 pulses follow. rtc_sdo is sampled at the end of each of those high phases and shifted into rdata bit 0, so the first bit received ends up as bit 31.
- R7: done is high for exactly one cycle, with err valid in the same cycle. With rtc_ready already high, done comes 1 + 72*HALF_CYC cycles after the acceptance edge and err is 0. rdata keeps its value until the next request is accepted.
- R8: A ready window lasts POLL_MAX cycles. If it ends without rtc_ready, the engine waits GAP_CYC = CLK_MHZ*GAP_US cycles and then polls again.
- R9: After INIT_TRIES consecutive empty windows, rtc_srst is held high for 2*HALF_CYC cycles. A GAP_CYC pause follows, and then a new round of windows starts.
- R10: When a round fails after RESET_MAX resets have already been issued, done comes with err = 1 and rtc_sen never rises. This happens (RESET_MAX+1)*INIT_TRIES*POLL_MAX + (RESET_MAX+1)*(INIT_TRIES-1)*GAP_CYC + RESET_MAX*(2*HALF_CYC+GAP_CYC) cycles after acceptance.
- R11: After the mode pulse, rtc_sdi stays 0: during the 32 read pulses, and in the idle cycle after any done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Slave address |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | A command is in progress |
| req_rej | output | 1 | One-cycle pulse: a command was refused |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Slave never became ready; valid with done |
| rdata | output | 32 | Word read from the slave |
| rtc_ready | input | 1 | Slave readiness flag |
| rtc_sdo | input | 1 | Slave serial data out |
| rtc_sen | output | 1 | Link enable |
| rtc_sclk | output | 1 | Link clock |
| rtc_sdi | output | 1 | Link serial data to the slave |
| rtc_srst | output | 1 | Slave reset strobe |

## Verification
With ready already high, rtc_sen is due 1 cycle after the acceptance edge and done is due 1 + 72*HALF_CYC cycles after it. A refusal pulse is due in the cycle after the refused strobe. The ready-timeout outcomes follow from the window, gap and reset lengths: a late ready gives rtc_sen POLL_MAX+GAP_CYC+1 cycles after acceptance, and a slave that never becomes ready ends with err at the sum stated in R10. The bench keeps a free-running edge counter and records the counter value of each event at the falling edge that follows it. It compares those values against latencies it computes from the parameters, and it measures every low phase, high phase and reset strobe length in whole cycles.

// File: rtl/rtl_link_master.sv
module rtl_link_master #(
  parameter int CLK_MHZ    = 125,
  parameter int HALF_US    = 5,
  parameter int GAP_US     = 100,
  parameter int POLL_MAX   = 40000,
  parameter int INIT_TRIES = 3,
  parameter int RESET_MAX  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [2:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        req_rej,
  output logic        done,
  output logic        err,
  output logic [31:0] rdata,
  input  logic        rtc_ready,
  input  logic        rtc_sdo,
  output logic        rtc_sen,
  output logic        rtc_sclk,
  output logic        rtc_sdi,
  output logic        rtc_srst
);
  localparam int HALF_CYC = CLK_MHZ * HALF_US;
  localparam int GAP_CYC  = CLK_MHZ * GAP_US;
  localparam int BIT_CYC  = 2 * HALF_CYC;
  localparam int TMAX0    = (POLL_MAX > GAP_CYC) ? POLL_MAX : GAP_CYC;
  localparam int TMAX     = (TMAX0 > BIT_CYC) ? TMAX0 : BIT_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int TRW      = $clog2(INIT_TRIES + 1);
  localparam int RSW      = $clog2(RESET_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_GAP, ST_SRST, ST_SEND, ST_MODE, ST_RECV
  } st_t;

  st_t         st;
  logic [TW-1:0]  tcnt;
  logic [TRW-1:0] tries;
  logic [RSW-1:0] resets;
  logic [34:0] sreg;
  logic [5:0]  bleft;
  logic        wr_q, sen_q, done_q, err_q, rej_q;
  logic [31:0] rdata_q;

  wire in_pulse  = (st == ST_SEND) || (st == ST_MODE) || (st == ST_RECV);
  wire pulse_end = in_pulse && (tcnt == TW'(BIT_CYC - 1));

  assign busy     = (st != ST_IDLE);
  assign req_rej  = rej_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rdata    = rdata_q;
  assign rtc_sen  = sen_q;
  assign rtc_sclk = in_pulse && (tcnt >= TW'(HALF_CYC));
  assign rtc_sdi  = (st == ST_SEND) ? sreg[34] : ((st == ST_MODE) && wr_q);
  assign rtc_srst = (st == ST_SRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      tries   <= '0;
      resets  <= '0;
      sreg    <= '0;
      bleft   <= '0;
      wr_q    <= 1'b0;
      sen_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rej_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= req_valid && (st != ST_IDLE);
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            wr_q   <= req_write;
            sreg   <= req_write ? {req_wdata, req_addr} : {req_addr, 32'd0};
            bleft  <= req_write ? 6'd35 : 6'd3;
            tries  <= '0;
            resets <= '0;
            tcnt   <= '0;
            st     <= ST_POLL;
          end
        end
        ST_POLL: begin
          if (rtc_ready) begin
            sen_q <= 1'b1;
            tcnt  <= '0;
            st    <= ST_SEND;
          end else if (tcnt == TW'(POLL_MAX - 1)) begin
            tcnt <= '0;
            if (tries == TRW'(INIT_TRIES - 1)) begin
              tries <= '0;
              if (resets == RSW'(RESET_MAX)) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
                st     <= ST_IDLE;
              end else begin
                resets <= resets + 1'b1;
                st     <= ST_SRST;
              end
            end else begin
              tries <= tries + 1'b1;
              st    <= ST_GAP;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_SRST: begin
          if (tcnt == TW'(BIT_CYC - 1)) begin
            tcnt <= '0;
            st   <= ST_GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (tcnt == TW'(GAP_CYC - 1)) begin
            tcnt <= '0;
            st   <= ST_POLL;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_SEND: begin
          if (pulse_end) begin
            tcnt  <= '0;
            sreg  <= {sreg[33:0], 1'b0};
            bleft <= bleft - 1'b1;
            if (bleft == 6'd1) begin
              sen_q <= 1'b0;
              st    <= ST_MODE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_MODE: begin
          if (pulse_end) begin
            tcnt <= '0;
            if (wr_q) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              bleft <= 6'd32;
              st    <= ST_RECV;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECV: begin
          if (pulse_end) begin
            tcnt    <= '0;
            rdata_q <= {rdata_q[30:0], rtc_sdo};
            bleft   <= bleft - 1'b1;
            if (bleft == 6'd1) begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module rtl_link_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        req_rej,
  input logic        done,
  input logic        err,
  input logic [31:0] rdata,
  input logic        rtc_ready,
  input logic        rtc_sen,
  input logic        rtc_sclk,
  input logic        rtc_sdi,
  input logic        rtc_srst
);
  // R2
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && busy |=> req_rej);
  // R2
  refuse_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> !req_rej);
  // R3
  sen_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_sen) |-> $past(rtc_ready));
  // R4
  sdi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_sclk && $past(rtc_sclk) |-> $stable(rtc_sdi) && $stable(rtc_sen));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!busy) |-> $stable(rdata));
  // R9
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_srst |-> !rtc_sen && !rtc_sclk);
  // R11
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rtc_sen && !rtc_sclk && !rtc_sdi && !rtc_srst);
endmodule

bind rtl_link_master rtl_link_master_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .req_rej(req_rej), .done(done), .err(err), .rdata(rdata),
  .rtc_ready(rtc_ready), .rtc_sen(rtc_sen), .rtc_sclk(rtc_sclk),
  .rtc_sdi(rtc_sdi), .rtc_srst(rtc_srst)
);

// File: tb/rtl_link_master_tb.sv
module rtl_link_master_tb_top;
  localparam int CLK_MHZ = 1, HALF_US = 2, GAP_US = 3, POLL_MAX = 5;
  localparam int INIT_TRIES = 3, RESET_MAX = 3;
  localparam int H = CLK_MHZ * HALF_US;
  localparam int G = CLK_MHZ * GAP_US;
  localparam int LAT_OK = 1 + 72 * H;
  localparam int LAT_ERR = (RESET_MAX + 1) * INIT_TRIES * POLL_MAX
                         + (RESET_MAX + 1) * (INIT_TRIES - 1) * G
                         + RESET_MAX * (2 * H + G);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic busy, req_rej, done, err, rtc_sen, rtc_sclk, rtc_sdi, rtc_srst;
  logic [31:0] rdata;
  logic rtc_ready = 1, rtc_sdo = 0;

  rtl_link_master #(.CLK_MHZ(CLK_MHZ), .HALF_US(HALF_US), .GAP_US(GAP_US),
    .POLL_MAX(POLL_MAX), .INIT_TRIES(INIT_TRIES), .RESET_MAX(RESET_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .req_rej(req_rej),
    .done(done), .err(err), .rdata(rdata), .rtc_ready(rtc_ready), .rtc_sdo(rtc_sdo),
    .rtc_sen(rtc_sen), .rtc_sclk(rtc_sclk), .rtc_sdi(rtc_sdi), .rtc_srst(rtc_srst));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  bit bits [0:63];
  bit senb [0:63];
  int nb = 0, lo_run = 0, hi_run = 0, srst_run = 0;
  int nrst = 0, ndone = 0, nrej = 0, sen_cyc = -1, done_cyc = 0, a_cyc = 0;
  bit done_err = 0, cur_wr = 0;
  logic [31:0] done_rd = 0, rword = 0;
  bit p_sclk = 0, p_sen = 0, p_srst = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rtc_sclk && !p_sclk) begin
        chk(lo_run == H, "R4 low phase length", lo_run, H);
        lo_run = 0;
        if (nb < 64) begin bits[nb] = rtc_sdi; senb[nb] = rtc_sen; end
        if (!cur_wr && nb >= 4 && nb < 36) rtc_sdo = rword[31 - (nb - 4)];
        nb++;
      end
      if (!rtc_sclk && p_sclk) begin
        chk(hi_run == H, "R4 high phase length", hi_run, H);
        hi_run = 0;
      end
      if (rtc_sclk) hi_run++;
      else if (busy && (rtc_sen || nb > 0)) lo_run++;
      if (rtc_sen && !p_sen) sen_cyc = cyc;
      if (rtc_srst && !p_srst) nrst++;
      if (rtc_srst) srst_run++;
      if (!rtc_srst && p_srst) begin
        chk(srst_run == 2 * H, "R9 reset strobe length", srst_run, 2 * H);
        srst_run = 0;
      end
      if (done) begin ndone++; done_cyc = cyc; done_err = err; done_rd = rdata; end
      if (req_rej) nrej++;
      p_sclk = rtc_sclk; p_sen = rtc_sen; p_srst = rtc_srst;
    end
  end

  int n0;
  task automatic start_req(input bit wr, input logic [2:0] ad, input logic [31:0] d, input logic [31:0] w);
    @(negedge clk);
    nb = 0; lo_run = 0; hi_run = 0; sen_cyc = -1; rtc_sdo = 0;
    cur_wr = wr; rword = w; n0 = ndone;
    req_valid = 1; req_write = wr; req_addr = ad; req_wdata = d;
    @(posedge clk);
    #1 a_cyc = cyc;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    while (ndone == n0) @(negedge clk);
    @(negedge clk);
    chk(!busy && !rtc_sen && !rtc_sclk && !rtc_sdi, "R11 lines low after done",
        {busy, rtc_sen, rtc_sclk, rtc_sdi}, 0);
  endtask

  task automatic check_write(input logic [2:0] ad, input logic [31:0] d);
    logic [31:0] gd = 0;
    logic [2:0] ga = 0;
    int ns = 0;
    chk(nb == 36, "R5 pulse count", nb, 36);
    for (int i = 0; i < 32; i++) gd = {gd[30:0], bits[i]};
    for (int i = 32; i < 35; i++) ga = {ga[1:0], bits[i]};
    for (int i = 0; i < 35; i++) ns += senb[i];
    chk(gd == d, "R5 data field", gd, d);
    chk(ga == ad, "R5 address field", ga, ad);
    chk(ns == 35, "R5 enable during fields", ns, 35);
    chk(bits[35] && !senb[35], "R5 mode bit 1 with enable low", {bits[35], senb[35]}, 2'b10);
    chk(done_cyc - a_cyc == LAT_OK, "R7 write done latency", done_cyc - a_cyc, LAT_OK);
    chk(sen_cyc - a_cyc == 1, "R3 enable latency", sen_cyc - a_cyc, 1);
    chk(!done_err, "R7 err low", done_err, 0);
  endtask

  task automatic check_read(input logic [2:0] ad, input logic [31:0] w);
    logic [2:0] ga = 0;
    int ns = 0, nz = 0;
    chk(nb == 36, "R6 pulse count", nb, 36);
    for (int i = 0; i < 3; i++) begin ga = {ga[1:0], bits[i]}; ns += senb[i]; end
    for (int i = 4; i < 36; i++) nz += bits[i] + senb[i];
    chk(ga == ad, "R6 address field", ga, ad);
    chk(ns == 3, "R6 enable during address", ns, 3);
    chk(!bits[3] && !senb[3], "R6 mode bit 0 with enable low", {bits[3], senb[3]}, 0);
    chk(nz == 0, "R11 data-out low during read pulses", nz, 0);
    chk(done_rd == w, "R6 read word", done_rd, w);
    chk(done_cyc - a_cyc == LAT_OK, "R7 read done latency", done_cyc - a_cyc, LAT_OK);
    chk(sen_cyc - a_cyc == 1, "R3 enable latency", sen_cyc - a_cyc, 1);
    chk(!done_err, "R7 err low", done_err, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, d;
    int r0, j0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, err, req_rej, rtc_sen, rtc_sclk, rtc_sdi, rtc_srst} == 0 && rdata == 0,
        "R1 reset state", {busy, done, err, req_rej, rtc_sen, rtc_sclk, rtc_sdi, rtc_srst}, 0);

    for (int ad = 0; ad < 8; ad++) begin
      w = 32'h9E3779B9 * (ad + 1) ^ (32'h1 << (ad * 4));
      d = ~w + ad * 32'h01010101;
      start_req(0, ad[2:0], 32'h0, w);
      wait_done();
      check_read(ad[2:0], w);
      start_req(1, ad[2:0], d, 32'h0);
      wait_done();
      check_write(ad[2:0], d);
      chk(rdata == w, "R7 rdata held across write", rdata, w);
    end

    j0 = nrej;
    start_req(1, 3'd5, 32'hA5C3_0F96, 32'h0);
    repeat (20) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'd2;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk(nrej - j0 == 1, "R2 refusal pulse", nrej - j0, 1);
    wait_done();
    check_write(3'd5, 32'hA5C3_0F96);
    repeat (200) @(negedge clk);
    chk(ndone - n0 == 1 && !busy, "R2 refused request dropped", ndone - n0, 1);

    rtc_ready = 0;
    r0 = nrst;
    start_req(0, 3'd6, 32'h0, 32'h1234_5678);
    while (cyc < a_cyc + POLL_MAX + 2) @(negedge clk);
    rtc_ready = 1;
    wait_done();
    chk(sen_cyc - a_cyc == POLL_MAX + G + 1, "R8 retry after gap", sen_cyc - a_cyc, POLL_MAX + G + 1);
    chk(nrst == r0, "R8 no reset in first round", nrst - r0, 0);
    chk(done_rd == 32'h1234_5678 && !done_err, "R8 read after retry", done_rd, 32'h1234_5678);

    rtc_ready = 0;
    r0 = nrst;
    start_req(0, 3'd1, 32'h0, 32'hCAFE_F00D);
    while (nrst == r0) @(negedge clk);
    while (rtc_srst) @(negedge clk);
    rtc_ready = 1;
    wait_done();
    chk(nrst - r0 == 1, "R9 one slave reset", nrst - r0, 1);
    chk(done_rd == 32'hCAFE_F00D && !done_err, "R9 read after reset", done_rd, 32'hCAFE_F00D);
    chk(sen_cyc - a_cyc == INIT_TRIES * POLL_MAX + (INIT_TRIES - 1) * G + 2 * H + G + 1,
        "R9 enable after reset round", sen_cyc - a_cyc,
        INIT_TRIES * POLL_MAX + (INIT_TRIES - 1) * G + 2 * H + G + 1);

    rtc_ready = 0;
    r0 = nrst;
    start_req(1, 3'd7, 32'hFFFF_0001, 32'h0);
    wait_done();
    chk(done_err, "R10 err on give-up", done_err, 1);
    chk(nrst - r0 == RESET_MAX, "R10 reset count", nrst - r0, RESET_MAX);
    chk(sen_cyc == -1 && nb == 0, "R10 no frame", nb, 0);
    chk(done_cyc - a_cyc == LAT_ERR, "R10 give-up latency", done_cyc - a_cyc, LAT_ERR);
    rtc_ready = 1;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule